// File: doc/BRIEF.md
# Register-Configured Digital Input/Output Router

This block routes a bank of digital input pins to a bank of digital output pins under register control. Each input channel owns a control register whose value chooses one of three behaviours for its matching output: block (drive 0), copy the input straight through, or copy it inverted. A per-bank output-select word then decides, bit by bit, whether each output pin takes the channel path result or a bit from a direct-output register.

Software talks to the block over a simple single-cycle register bus. Every configuration write lands in a shadow copy that has no effect on the pins. A write to a commit address copies the whole shadow set into the active set in one cycle, so that a multi-register reconfiguration reaches the pins all at once. A separate run bit is not shadowed: it drives a small group of active-low reset pins for external logic directly. Two read-only monitor addresses return the sampled inputs and the current outputs.

Top module: `dio_route`

## Requirements
- R1: While reset is asserted and right after it, every shadow and active register is 0, the output pins are 0, the reset pins are 0 and the read data is 0.
- R2: Writing bit 0 of the run register (address 0x30) sets every pin of `ext_rst_n` to that value from the cycle after the write; a commit has no influence on it.
- R3: Writes to the channel control (0x00 + n), output-select (0x20) and direct-output (0x21) registers change nothing on `dout` until a write of any value to the commit address 0x31; the commit copies all shadow registers into the active set at once.
- R4: A channel whose active control value is 0x0001 and whose output-select bit is 1 drives `dout[n]` with `din[n]`, two clock edges after `din` changes (one sampling stage, one output register).
- R5: A channel whose active control value is 0x0003 and whose output-select bit is 1 drives `dout[n]` with the inverse of `din[n]`, with the same latency as R4.
- R6: A channel whose active control value is 0x0000, or any value other than 0x0001 and 0x0003, drives 0 on `dout[n]` when its output-select bit is 1.
- R7: Where the active output-select bit n is 0, `dout[n]` equals bit n of the active direct-output register; a select word of 0xFFFF routes every output from the channel path.
- R8: Reading address 0x40 returns the sampled input word and reading 0x41 returns the current `dout` word.
- R9: Reads of configuration addresses return the shadow values, the commit address and any unmapped address read as 0, and writes to the monitor addresses change nothing.
- R10: A read issued with `rd_en` returns its data on `rdata` after the next clock edge, and `rdata` holds its value in every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, registered |
| din | input | 16 | Digital input pins |
| dout | output | 16 | Digital output pins |
| ext_rst_n | output | 2 | Active-low reset pins for external logic, follow the run bit |

## Verification
The hardest situation to reach is a pending shadow configuration that differs from the active one while the inputs keep toggling, because only then can a leak of shadow state onto the pins be seen. The stimulus loads a full set of new modes, a select word and a direct word, then toggles `din` over several cycles before the commit, while a behavioural model in the bench is compared against `dout` on every clock. Mixed mode patterns (pass, invert, off and an undefined code) and partial select words are committed while inputs change, so every combination of path and direct bit is seen at the pins.

// File: rtl/dio_route_pkg.sv
package dio_route_pkg;

   localparam int unsigned REG_AW = 8;

   localparam int unsigned ADDR_CTRL_BASE = 'h00;
   localparam int unsigned ADDR_OSEL      = 'h20;
   localparam int unsigned ADDR_DIRECT    = 'h21;
   localparam int unsigned ADDR_RUN       = 'h30;
   localparam int unsigned ADDR_COMMIT    = 'h31;
   localparam int unsigned ADDR_IN_MON    = 'h40;
   localparam int unsigned ADDR_OUT_MON   = 'h41;

   localparam int unsigned CODE_PASS = 'h0001;
   localparam int unsigned CODE_INV  = 'h0003;

   typedef enum logic [1:0] {
      CH_OFF  = 2'd0,
      CH_PASS = 2'd1,
      CH_INV  = 2'd2
   } ch_mode_e;

endpackage

// File: rtl/dio_route_regs.sv
module dio_route_regs
   import dio_route_pkg::*;
#(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned DATA_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [REG_AW-1:0]             addr,
   input  logic [DATA_W-1:0]             wdata,
   output logic [NUM_CH-1:0][DATA_W-1:0] sh_ctrl,
   output logic [NUM_CH-1:0][DATA_W-1:0] act_ctrl,
   output logic [NUM_CH-1:0]             sh_osel,
   output logic [NUM_CH-1:0]             act_osel,
   output logic [NUM_CH-1:0]             sh_dir,
   output logic [NUM_CH-1:0]             act_dir,
   output logic                          run
);

   logic commit;
   logic wr_osel;
   logic wr_dir;
   logic wr_run;

   assign commit  = wr_en && (addr == REG_AW'(ADDR_COMMIT));
   assign wr_osel = wr_en && (addr == REG_AW'(ADDR_OSEL));
   assign wr_dir  = wr_en && (addr == REG_AW'(ADDR_DIRECT));
   assign wr_run  = wr_en && (addr == REG_AW'(ADDR_RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_ctrl  <= '0;
         act_ctrl <= '0;
      end else begin
         for (int n = 0; n < NUM_CH; n++) begin
            if (wr_en && (addr == REG_AW'(ADDR_CTRL_BASE + n)))
               sh_ctrl[n] <= wdata;
         end
         if (commit)
            act_ctrl <= sh_ctrl;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_osel  <= '0;
         act_osel <= '0;
         sh_dir   <= '0;
         act_dir  <= '0;
      end else begin
         if (wr_osel)
            sh_osel <= wdata[NUM_CH-1:0];
         if (wr_dir)
            sh_dir <= wdata[NUM_CH-1:0];
         if (commit) begin
            act_osel <= sh_osel;
            act_dir  <= sh_dir;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run <= 1'b0;
      else if (wr_run)
         run <= wdata[0];
   end

   assert_hold_without_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(act_osel) && $stable(act_dir) && $stable(act_ctrl)));

   assert_commit_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (act_osel == $past(sh_osel) && act_dir == $past(sh_dir)
                  && act_ctrl == $past(sh_ctrl)));

   assert_run_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_run |=> (run == $past(wdata[0])));

   assert_run_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_run |=> $stable(run));

endmodule

// File: rtl/dio_route_insamp.sv
module dio_route_insamp #(
   parameter int unsigned NUM_CH = 16,
   parameter int unsigned STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] din,
   output logic [NUM_CH-1:0] din_q
);

   if (STAGES < 1 || STAGES > 3) begin : g_bad_stages
      $error("dio_route_insamp: STAGES must be 1 to 3");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            din_q <= '0;
         else
            din_q <= din;
      end
   end else begin : g_chain
      logic [STAGES-1:0][NUM_CH-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pipe <= '0;
         else
            pipe <= {pipe[STAGES-2:0], din};
      end
      assign din_q = pipe[STAGES-1];
   end

endmodule

// File: rtl/dio_route_chan.sv
module dio_route_chan
   import dio_route_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic [DATA_W-1:0] ctrl,
   input  logic              in_bit,
   output ch_mode_e          mode,
   output logic              path_bit
);

   always_comb begin
      if (ctrl == DATA_W'(CODE_PASS))
         mode = CH_PASS;
      else if (ctrl == DATA_W'(CODE_INV))
         mode = CH_INV;
      else
         mode = CH_OFF;
   end

   always_comb begin
      unique case (mode)
         CH_PASS: path_bit = in_bit;
         CH_INV:  path_bit = ~in_bit;
         default: path_bit = 1'b0;
      endcase
   end

endmodule

// File: rtl/dio_route_outsel.sv
module dio_route_outsel #(
   parameter int unsigned NUM_CH = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] path,
   input  logic [NUM_CH-1:0] osel,
   input  logic [NUM_CH-1:0] direct,
   output logic [NUM_CH-1:0] dout
);

   logic [NUM_CH-1:0] mux;

   for (genvar n = 0; n < NUM_CH; n++) begin : g_bit
      assign mux[n] = osel[n] ? path[n] : direct[n];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dout <= '0;
      else
         dout <= mux;
   end

   assert_direct_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((dout & ~$past(osel)) == ($past(direct) & ~$past(osel))));

endmodule

// File: rtl/dio_route.sv
module dio_route
   import dio_route_pkg::*;
#(
   parameter int unsigned NUM_CH    = 16,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_RST   = 2,
   parameter int unsigned IN_STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [REG_AW-1:0]  addr,
   input  logic [DATA_W-1:0]  wdata,
   output logic [DATA_W-1:0]  rdata,
   input  logic [NUM_CH-1:0]  din,
   output logic [NUM_CH-1:0]  dout,
   output logic [NUM_RST-1:0] ext_rst_n
);

   if (NUM_CH < 1 || NUM_CH > 32) begin : g_bad_ch
      $error("dio_route: NUM_CH must be 1 to 32");
   end
   if (NUM_CH > DATA_W) begin : g_bad_width
      $error("dio_route: NUM_CH must not exceed DATA_W");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("dio_route: DATA_W must hold the mode codes");
   end
   if (NUM_RST < 1) begin : g_bad_rst
      $error("dio_route: NUM_RST must be at least 1");
   end

   logic [NUM_CH-1:0][DATA_W-1:0] sh_ctrl;
   logic [NUM_CH-1:0][DATA_W-1:0] act_ctrl;
   logic [NUM_CH-1:0]             sh_osel;
   logic [NUM_CH-1:0]             act_osel;
   logic [NUM_CH-1:0]             sh_dir;
   logic [NUM_CH-1:0]             act_dir;
   logic                          run;
   logic [NUM_CH-1:0]             din_q;
   logic [NUM_CH-1:0]             path;
   ch_mode_e                      mode [NUM_CH];
   logic [DATA_W-1:0]             rd_val;

   dio_route_regs #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .addr     (addr),
      .wdata    (wdata),
      .sh_ctrl  (sh_ctrl),
      .act_ctrl (act_ctrl),
      .sh_osel  (sh_osel),
      .act_osel (act_osel),
      .sh_dir   (sh_dir),
      .act_dir  (act_dir),
      .run      (run)
   );

   dio_route_insamp #(
      .NUM_CH (NUM_CH),
      .STAGES (IN_STAGES)
   ) u_insamp (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (din),
      .din_q (din_q)
   );

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chan
      dio_route_chan #(
         .DATA_W (DATA_W)
      ) u_chan (
         .ctrl     (act_ctrl[n]),
         .in_bit   (din_q[n]),
         .mode     (mode[n]),
         .path_bit (path[n])
      );
   end

   dio_route_outsel #(
      .NUM_CH (NUM_CH)
   ) u_outsel (
      .clk    (clk),
      .rst_n  (rst_n),
      .path   (path),
      .osel   (act_osel),
      .direct (act_dir),
      .dout   (dout)
   );

   assign ext_rst_n = run ? {NUM_RST{1'b1}} : {NUM_RST{1'b0}};

   always_comb begin
      rd_val = '0;
      for (int n = 0; n < NUM_CH; n++) begin
         if (addr == REG_AW'(ADDR_CTRL_BASE + n))
            rd_val = sh_ctrl[n];
      end
      if (addr == REG_AW'(ADDR_OSEL))
         rd_val = DATA_W'(sh_osel);
      else if (addr == REG_AW'(ADDR_DIRECT))
         rd_val = DATA_W'(sh_dir);
      else if (addr == REG_AW'(ADDR_RUN))
         rd_val = DATA_W'(run);
      else if (addr == REG_AW'(ADDR_IN_MON))
         rd_val = DATA_W'(din_q);
      else if (addr == REG_AW'(ADDR_OUT_MON))
         rd_val = DATA_W'(dout);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= rd_val;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         assert_reset_clear_R1: assert (dout == '0 && rdata == '0 && ext_rst_n == '0);
      end
   end

   assert_rst_pins_agree_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(ext_rst_n) == 0) || ($countones(ext_rst_n) == NUM_RST));

   assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
      assert_off_drives_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (act_osel[n] && act_ctrl[n] != DATA_W'(CODE_PASS) && act_ctrl[n] != DATA_W'(CODE_INV))
         |=> (dout[n] == 1'b0));

      assert_pass_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (act_osel[n] && act_ctrl[n] == DATA_W'(CODE_PASS)) |=> (dout[n] == $past(din_q[n])));

      assert_inv_copies_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (act_osel[n] && act_ctrl[n] == DATA_W'(CODE_INV)) |=> (dout[n] == !$past(din_q[n])));
   end

endmodule

// File: tb/tb_dio_route.sv
module tb_dio_route;

   localparam int NCH = 16;
   localparam int DW  = 16;
   localparam int NR  = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic           rd_en = 1'b0;
   logic [7:0]     addr = '0;
   logic [DW-1:0]  wdata = '0;
   logic [DW-1:0]  rdata;
   logic [NCH-1:0] din = '0;
   logic [NCH-1:0] dout;
   logic [NR-1:0]  ext_rst_n;

   always #5 clk = ~clk;

   dio_route dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .din       (din),
      .dout      (dout),
      .ext_rst_n (ext_rst_n)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference model
   logic [DW-1:0]  m_sh_ctrl  [NCH];
   logic [DW-1:0]  m_act_ctrl [NCH];
   logic [NCH-1:0] m_sh_osel = '0, m_act_osel = '0, m_sh_dir = '0, m_act_dir = '0;
   logic           m_run = 1'b0;
   logic [NCH-1:0] m_in = '0, m_dout = '0;
   logic [DW-1:0]  m_rdata = '0;

   initial begin
      for (int i = 0; i < NCH; i++) begin
         m_sh_ctrl[i]  = '0;
         m_act_ctrl[i] = '0;
      end
   end

   function automatic logic [NCH-1:0] route(input logic [NCH-1:0] in_w);
      logic [NCH-1:0] r;
      for (int i = 0; i < NCH; i++) begin
         logic p;
         if (m_act_ctrl[i] == 16'h0001)      p = in_w[i];
         else if (m_act_ctrl[i] == 16'h0003) p = ~in_w[i];
         else                                p = 1'b0;
         r[i] = m_act_osel[i] ? p : m_act_dir[i];
      end
      return r;
   endfunction

   function automatic logic [DW-1:0] model_read(input logic [7:0] a);
      if (a < NCH) return m_sh_ctrl[a];
      case (a)
         8'h20:   return m_sh_osel;
         8'h21:   return m_sh_dir;
         8'h30:   return {15'd0, m_run};
         8'h40:   return m_in;
         8'h41:   return m_dout;
         default: return '0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         logic [NCH-1:0] nxt;
         nxt = route(m_in);
         if (rd_en) m_rdata = model_read(addr);
         m_in = din;
         if (wr_en) begin
            if (addr < NCH) m_sh_ctrl[addr] = wdata;
            else if (addr == 8'h20) m_sh_osel = wdata;
            else if (addr == 8'h21) m_sh_dir = wdata;
            else if (addr == 8'h30) m_run = wdata[0];
            else if (addr == 8'h31) begin
               for (int i = 0; i < NCH; i++) m_act_ctrl[i] = m_sh_ctrl[i];
               m_act_osel = m_sh_osel;
               m_act_dir  = m_sh_dir;
            end
         end
         m_dout = nxt;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(dout == m_dout, "R4 R5 R6 R7 per-cycle dout", dout, m_dout);
         check(ext_rst_n == (m_run ? 2'b11 : 2'b00), "R2 per-cycle ext_rst_n", ext_rst_n, m_run ? 2'b11 : 2'b00);
         check(rdata == m_rdata, "R10 per-cycle rdata", rdata, m_rdata);
      end
   end

   task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   task automatic idle(input int c);
      repeat (c) @(negedge clk);
   endtask

   function automatic logic [NCH-1:0] mixed_expect(input logic [NCH-1:0] in_w);
      logic [NCH-1:0] r;
      for (int i = 0; i < NCH; i++) begin
         case (i % 4)
            1:       r[i] = in_w[i];
            3:       r[i] = ~in_w[i];
            default: r[i] = 1'b0;
         endcase
      end
      return r;
   endfunction

   initial begin
      logic [DW-1:0] v;
      // R1: reset state
      idle(2);
      check(dout == '0, "R1 dout in reset", dout, 0);
      check(ext_rst_n == '0, "R1 ext_rst_n in reset", ext_rst_n, 0);
      check(rdata == '0, "R1 rdata in reset", rdata, 0);
      rst_n = 1'b1;
      idle(1);
      rd(8'h20, v);
      check(v == '0, "R1 osel shadow after reset", v, 0);

      // R2: run bit drives the external reset pins
      wr(8'h30, 16'h0001);
      check(ext_rst_n == 2'b11, "R2 start", ext_rst_n, 2'b11);
      wr(8'h30, 16'h0000);
      check(ext_rst_n == 2'b00, "R2 stop", ext_rst_n, 2'b00);
      wr(8'h30, 16'h0001);
      wr(8'h31, 16'h0000);
      check(ext_rst_n == 2'b11, "R2 commit leaves run", ext_rst_n, 2'b11);

      // R3: shadow writes are invisible until commit
      din = 16'hFFFF;
      wr(8'h00, 16'h0001);
      wr(8'h01, 16'h0003);
      wr(8'h20, 16'hFFFF);
      din = 16'h0000; idle(2); din = 16'hFFFF; idle(3);
      check(dout == 16'h0000, "R3 no effect before commit", dout, 16'h0000);
      wr(8'h31, 16'h1234);
      idle(1);
      check(dout == 16'h0001, "R4 R5 pass and invert din=FFFF", dout, 16'h0001);
      din = 16'h0000; idle(2);
      check(dout == 16'h0002, "R4 R5 pass and invert din=0000", dout, 16'h0002);

      // R6: mixed modes incl. undefined code, all outputs from path
      for (int i = 0; i < NCH; i++) begin
         case (i % 4)
            0: wr(8'(i), 16'h0000);
            1: wr(8'(i), 16'h0001);
            2: wr(8'(i), 16'h0005);
            default: wr(8'(i), 16'h0003);
         endcase
         din = ~din;
      end
      wr(8'h31, 16'h0000);
      foreach (din[k]) begin end
      din = 16'hA5C3; idle(2);
      check(dout == mixed_expect(16'hA5C3), "R6 mixed modes A5C3", dout, mixed_expect(16'hA5C3));
      din = 16'h3C96; idle(2);
      check(dout == mixed_expect(16'h3C96), "R6 mixed modes 3C96", dout, mixed_expect(16'h3C96));

      // R7: partial select with direct-output bits
      wr(8'h20, 16'h00FF);
      wr(8'h21, 16'hAB00);
      din = 16'h0F0F; idle(2);
      check(dout == mixed_expect(16'h0F0F), "R3 partial select pending", dout, mixed_expect(16'h0F0F));
      wr(8'h31, 16'h0000);
      idle(1);
      check(dout == ((mixed_expect(16'h0F0F) & 16'h00FF) | 16'hAB00), "R7 direct upper byte",
            dout, (mixed_expect(16'h0F0F) & 16'h00FF) | 16'hAB00);
      wr(8'h20, 16'h0000); wr(8'h21, 16'h5A5A); wr(8'h31, 16'h0000); idle(1);
      check(dout == 16'h5A5A, "R7 all direct", dout, 16'h5A5A);

      // R8: monitors
      din = 16'hC0DE; idle(2);
      rd(8'h40, v);
      check(v == 16'hC0DE, "R8 input monitor", v, 16'hC0DE);
      rd(8'h41, v);
      check(v == 16'h5A5A, "R8 output monitor", v, 16'h5A5A);

      // R9: shadow readback, unmapped and read-only
      wr(8'h05, 16'hBEEF);
      rd(8'h05, v);
      check(v == 16'hBEEF, "R9 shadow readback", v, 16'hBEEF);
      rd(8'h31, v);
      check(v == 16'h0000, "R9 commit reads 0", v, 0);
      rd(8'h77, v);
      check(v == 16'h0000, "R9 unmapped reads 0", v, 0);
      wr(8'h40, 16'h1111);
      wr(8'h41, 16'h2222);
      rd(8'h40, v);
      check(v == 16'hC0DE, "R9 input monitor write ignored", v, 16'hC0DE);
      check(dout == 16'h5A5A, "R9 output monitor write ignored", dout, 16'h5A5A);

      // R10: rdata holds without rd_en
      rd(8'h21, v);
      din = 16'h1357; idle(4);
      check(rdata == 16'h5A5A, "R10 rdata holds", rdata, 16'h5A5A);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "R1 watchdog expired", 0, 1);
         end
      join_any
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule